// File: doc/BRIEF.md
# Kernel Dispatch Retry Scheduler

This block keeps the identifiers of launched compute kernels in a ring-ordered queue and, during scheduling passes, hands their workgroups to a shader array one at a time. Each kernel has a table slot, indexed by its identifier, that holds its workgroup total, the index of the next workgroup to hand out and a flag that records whether its cache invalidate has already been requested. When the acquire option is on, a kernel may dispatch only once the invalidate status bit for that kernel is high. When the option is off, the kernel counts as ready straight away.

A pass services the queue head once per clock. A kernel that cannot make progress goes back to the tail of the queue, and the pass counts that as a failure. This happens when the kernel is not yet ready, or when the shader refuses one of its workgroups. The pass ends as soon as the queue occupancy is no larger than the failure count. A blocked head therefore never stalls the kernels behind it. A refused kernel resumes later at the workgroup it was refused on.

A new pass is booked by any of three events: an accepted launch, a rising invalidate-done bit, or a workgroup-completion pulse. The pass starts on the clock after it is booked. Launches are taken only between passes.

Top module: `kds_sched`

## Requirements
- R1: A launch is taken (launch_valid and launch_ready high at a clock edge) only while no pass runs and the queue holds fewer than QDEPTH identifiers. launch_ready is low whenever the queue is full. A taken identifier joins the queue tail.
- R2: stat_launch increases by one on every taken launch. stat_stall increases by one on every pass that starts with a non-empty queue.
- R3: A pass is booked after a taken launch, after any bit of inv_done_vec rises, or after a wg_done pulse. It starts on the following clock, provided no pass is running.
- R4: With acq_en high, inv_req pulses for one cycle, with inv_req_kid equal to the kernel, the first time that kernel reaches the queue head, and never again for that kernel. The kernel is ready only while inv_done_vec[kernel] is 1. With acq_en low, inv_req stays low and every kernel is ready.
- R5: A head kernel that is not ready is moved to the tail and adds one failure. A pass ends once the occupancy is no larger than its failure count, and no workgroup of a kernel that is not ready is offered.
- R6: A ready head kernel offers workgroups on wg_valid with wg_kid equal to its identifier and wg_idx counting up from 0. Each cycle in which wg_accept is high advances the index by one.
- R7: A refused workgroup (wg_valid high, wg_accept low) moves the kernel to the tail and adds one failure. The next retry offers the same wg_idx again.
- R8: Once the workgroup with index launch_wgs-1 is accepted, the kernel leaves the queue and is never offered again. launch_wgs must be nonzero.
- R9: Rotations that pass over the whole queue keep launch order, so kernels that become ready together dispatch in the order they were launched.
- R10: After reset, launch_ready is 1, wg_valid and inv_req are 0, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquire-on-launch option: request invalidate before dispatch |
| launch_valid | input | 1 | Launch request |
| launch_ready | output | 1 | Launch can be taken this cycle |
| launch_kid | input | KID_W | Identifier of the launched kernel |
| launch_wgs | input | WG_W | Workgroup total of the launched kernel (nonzero) |
| inv_done_vec | input | 2**KID_W | Per-kernel invalidate-complete status |
| inv_req | output | 1 | Invalidate request pulse |
| inv_req_kid | output | KID_W | Kernel the invalidate is requested for |
| wg_valid | output | 1 | Workgroup offered to the shader |
| wg_kid | output | KID_W | Kernel of the offered workgroup |
| wg_idx | output | WG_W | Index of the offered workgroup |
| wg_accept | input | 1 | Shader takes the offered workgroup |
| wg_done | input | 1 | A workgroup finished (books a pass) |
| stat_launch | output | CNT_W | Launched kernel count |
| stat_stall | output | CNT_W | Passes started with a non-empty queue |

## Verification
First, single kernels of several sizes are run alone with an always-accepting shader. This separates correct index counting and removal from off-by-one ends. Two kernels waiting on invalidates, released in reverse order, show whether a blocked head is rotated past rather than waited on, and show that each request is issued once. A shader that refuses one particular index shows whether the retry resumes at that index and not at zero or one past it. Filling the queue against a shader that refuses everything checks the full-queue refusal, checks that launch order survives repeated whole-queue rotation, and checks the stall count.

// File: rtl/kds_pkg.sv
package kds_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PASS = 1'b1
    } kds_state_e;
endpackage

// File: rtl/kds_idq.sv
// Ring-ordered identifier queue: push at tail, pop at head, or rotate head to tail.
module kds_idq #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ID_W-1:0]  push_id,
    input  logic             pop,
    input  logic             rot,
    output logic [ID_W-1:0]  head_id,
    output logic [CNT_W-1:0] count
);
    logic [DEPTH-1:0][ID_W-1:0] mem_d, mem_q;
    logic [PTR_W-1:0]           hd_d, hd_q, tl_d, tl_q;
    logic [CNT_W-1:0]           cnt_d, cnt_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        mem_d = mem_q;
        hd_d  = hd_q;
        tl_d  = tl_q;
        cnt_d = cnt_q;
        if (push) begin
            mem_d[tl_q] = push_id;
            tl_d        = step(tl_q);
            cnt_d       = cnt_q + 1'b1;
        end else if (rot) begin
            mem_d[tl_q] = mem_q[hd_q];
            hd_d        = step(hd_q);
            tl_d        = step(tl_q);
        end else if (pop) begin
            hd_d  = step(hd_q);
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
        end else begin
            mem_q <= mem_d;
            hd_q  <= hd_d;
            tl_q  <= tl_d;
            cnt_q <= cnt_d;
        end
    end

    assign head_id = mem_q[hd_q];
    assign count   = cnt_q;
endmodule

// File: rtl/kds_wake.sv
// Books a scheduling pass on launch, invalidate completion or workgroup completion.
module kds_wake #(
    parameter int NK = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_fire,
    input  logic          wg_done,
    input  logic [NK-1:0] inv_done_vec,
    input  logic          take,
    output logic          pending
);
    logic [NK-1:0] prev_d, prev_q;
    logic          pend_d, pend_q;
    logic          rise;

    always_comb begin
        rise   = |(inv_done_vec & ~prev_q);
        prev_d = inv_done_vec;
        pend_d = (pend_q && !take) || launch_fire || wg_done || rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/kds_sched.sv
module kds_sched
    import kds_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int KID_W  = 3,
    parameter int WG_W   = 6,
    parameter int CNT_W  = 16,
    localparam int NK    = 1 << KID_W,
    localparam int QC_W  = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_en,
    input  logic              launch_valid,
    output logic              launch_ready,
    input  logic [KID_W-1:0]  launch_kid,
    input  logic [WG_W-1:0]   launch_wgs,
    input  logic [NK-1:0]     inv_done_vec,
    output logic              inv_req,
    output logic [KID_W-1:0]  inv_req_kid,
    output logic              wg_valid,
    output logic [KID_W-1:0]  wg_kid,
    output logic [WG_W-1:0]   wg_idx,
    input  logic              wg_accept,
    input  logic              wg_done,
    output logic [CNT_W-1:0]  stat_launch,
    output logic [CNT_W-1:0]  stat_stall
);
    typedef struct packed {
        kds_state_e                st;
        logic [QC_W-1:0]           fails;
        logic [NK-1:0][WG_W-1:0]   tot;
        logic [NK-1:0][WG_W-1:0]   nxt;
        logic [NK-1:0]             isent;
        logic [CNT_W-1:0]          n_launch;
        logic [CNT_W-1:0]          n_stall;
    } regs_t;

    regs_t            r_d, r_q;
    logic             q_push, q_pop, q_rot, take, pending, launch_fire;
    logic             active, kready;
    logic [KID_W-1:0] head_kid;
    logic [QC_W-1:0]  q_count;

    kds_idq #(.DEPTH(QDEPTH), .ID_W(KID_W)) u_idq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (q_push),
        .push_id (launch_kid),
        .pop     (q_pop),
        .rot     (q_rot),
        .head_id (head_kid),
        .count   (q_count)
    );

    kds_wake #(.NK(NK)) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_fire  (launch_fire),
        .wg_done      (wg_done),
        .inv_done_vec (inv_done_vec),
        .take         (take),
        .pending      (pending)
    );

    always_comb begin
        r_d    = r_q;
        q_push = 1'b0;
        q_pop  = 1'b0;
        q_rot  = 1'b0;
        take   = 1'b0;

        launch_ready = (r_q.st == ST_IDLE) && (q_count != QC_W'(QDEPTH));
        launch_fire  = launch_valid && launch_ready;
        active       = (r_q.st == ST_PASS) && (q_count > r_q.fails);
        kready       = !acq_en || inv_done_vec[head_kid];
        inv_req      = active && acq_en && !r_q.isent[head_kid];
        inv_req_kid  = head_kid;
        wg_valid     = active && kready;
        wg_kid       = head_kid;
        wg_idx       = r_q.nxt[head_kid];

        if (launch_fire) begin
            q_push                  = 1'b1;
            r_d.tot[launch_kid]     = launch_wgs;
            r_d.nxt[launch_kid]     = '0;
            r_d.isent[launch_kid]   = 1'b0;
            r_d.n_launch            = r_q.n_launch + 1'b1;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (pending) begin
                    take      = 1'b1;
                    r_d.st    = ST_PASS;
                    r_d.fails = '0;
                    if (q_count != '0) begin
                        r_d.n_stall = r_q.n_stall + 1'b1;
                    end
                end
            end
            default: begin
                if (!active) begin
                    r_d.st = ST_IDLE;
                end else begin
                    if (inv_req) begin
                        r_d.isent[head_kid] = 1'b1;
                    end
                    if (kready && wg_accept) begin
                        r_d.nxt[head_kid] = r_q.nxt[head_kid] + 1'b1;
                        if (WG_W'(r_q.nxt[head_kid] + 1'b1) == r_q.tot[head_kid]) begin
                            q_pop = 1'b1;
                        end
                    end else begin
                        q_rot     = 1'b1;
                        r_d.fails = r_q.fails + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stat_launch = r_q.n_launch;
    assign stat_stall  = r_q.n_stall;
endmodule

// File: rtl/kds_sched_chk.sv
module kds_sched_chk #(
    parameter int QDEPTH = 4,
    parameter int KID_W  = 3,
    parameter int WG_W   = 6,
    parameter int CNT_W  = 16,
    localparam int NK    = 1 << KID_W,
    localparam int QC_W  = $clog2(QDEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acq_en,
    input logic             launch_valid,
    input logic             launch_ready,
    input logic [NK-1:0]    inv_done_vec,
    input logic             inv_req,
    input logic             wg_valid,
    input logic [KID_W-1:0] wg_kid,
    input logic [WG_W-1:0]  wg_idx,
    input logic             wg_accept,
    input logic [CNT_W-1:0] stat_launch,
    input logic [CNT_W-1:0] stat_stall,
    input logic [QC_W-1:0]  q_count
);
    assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QC_W'(QDEPTH));

    assert_full_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == QC_W'(QDEPTH)) |-> !launch_ready);

    assert_launch_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_ready) |=> ((stat_launch - $past(stat_launch)) == CNT_W'(1)));

    assert_stall_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((stat_stall - $past(stat_stall)) <= CNT_W'(1)));

    assert_no_inv_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_en |-> !inv_req);

    assert_wg_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wg_valid && acq_en) |-> inv_done_vec[wg_kid]);

    assert_wg_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wg_valid && wg_accept) |=>
            (!wg_valid || (wg_kid != $past(wg_kid)) || ((wg_idx - $past(wg_idx)) == WG_W'(1))));
endmodule

bind kds_sched kds_sched_chk #(
    .QDEPTH (QDEPTH),
    .KID_W  (KID_W),
    .WG_W   (WG_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acq_en       (acq_en),
    .launch_valid (launch_valid),
    .launch_ready (launch_ready),
    .inv_done_vec (inv_done_vec),
    .inv_req      (inv_req),
    .wg_valid     (wg_valid),
    .wg_kid       (wg_kid),
    .wg_idx       (wg_idx),
    .wg_accept    (wg_accept),
    .stat_launch  (stat_launch),
    .stat_stall   (stat_stall),
    .q_count      (q_count)
);

// File: tb/kds_sched_tb.sv
`timescale 1ns/1ps
module kds_sched_tb;
    localparam int QDEPTH = 4;
    localparam int KID_W  = 3;
    localparam int WG_W   = 6;
    localparam int CNT_W  = 16;
    localparam int NK     = 1 << KID_W;

    // stimulus table: kernel id, workgroup total, expected last index
    localparam int NV = 5;
    localparam int T_KID  [NV] = '{1, 3, 7, 0, 4};
    localparam int T_NWG  [NV] = '{1, 4, 6, 2, 3};
    localparam int T_LAST [NV] = '{0, 3, 5, 1, 2};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acq_en = 1'b0;
    logic             launch_valid = 1'b0;
    logic             launch_ready;
    logic [KID_W-1:0] launch_kid = '0;
    logic [WG_W-1:0]  launch_wgs = '0;
    logic [NK-1:0]    inv_done_vec = '0;
    logic             inv_req;
    logic [KID_W-1:0] inv_req_kid;
    logic             wg_valid;
    logic [KID_W-1:0] wg_kid;
    logic [WG_W-1:0]  wg_idx;
    logic             wg_accept;
    logic             wg_done = 1'b0;
    logic [CNT_W-1:0] stat_launch, stat_stall;

    logic             acc = 1'b1;
    logic             refuse_en = 1'b0;
    logic [WG_W-1:0]  refuse_idx = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int log_n = 0;
    int inv_n = 0;
    int log_kid [64];
    int log_idx [64];
    int inv_log [64];

    always #5 clk = ~clk;

    assign wg_accept = acc && !(refuse_en && (wg_idx == refuse_idx));

    kds_sched #(.QDEPTH(QDEPTH), .KID_W(KID_W), .WG_W(WG_W), .CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .acq_en       (acq_en),
        .launch_valid (launch_valid),
        .launch_ready (launch_ready),
        .launch_kid   (launch_kid),
        .launch_wgs   (launch_wgs),
        .inv_done_vec (inv_done_vec),
        .inv_req      (inv_req),
        .inv_req_kid  (inv_req_kid),
        .wg_valid     (wg_valid),
        .wg_kid       (wg_kid),
        .wg_idx       (wg_idx),
        .wg_accept    (wg_accept),
        .wg_done      (wg_done),
        .stat_launch  (stat_launch),
        .stat_stall   (stat_stall)
    );

    // record transfers between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (wg_valid && wg_accept && log_n < 64) begin
                log_kid[log_n] = int'(wg_kid);
                log_idx[log_n] = int'(wg_idx);
                log_n++;
            end
            if (inv_req && inv_n < 64) begin
                inv_log[inv_n] = int'(inv_req_kid);
                inv_n++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic launch(input int kid, input int nwg);
        @(posedge clk); #1;
        while (!launch_ready) begin
            @(posedge clk); #1;
        end
        launch_kid   = KID_W'(kid);
        launch_wgs   = WG_W'(nwg);
        launch_valid = 1'b1;
        @(posedge clk); #1;
        launch_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (25) @(posedge clk);
        #1;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1;
        wg_done = 1'b1;
        @(posedge clk); #1;
        wg_done = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 launch_ready", int'(launch_ready), 1);
        chk("R10 wg_valid", int'(wg_valid), 0);
        chk("R10 inv_req", int'(inv_req), 0);
        chk("R10 stat_launch", int'(stat_launch), 0);
        chk("R10 stat_stall", int'(stat_stall), 0);
        rst_n = 1'b1;
        settle();
        chk("R3 no pass without trigger", int'(stat_stall), 0);

        // table walk: single kernels, shader always accepts, no acquire
        for (int v = 0; v < NV; v++) begin
            base = log_n;
            launch(T_KID[v], T_NWG[v]);
            settle();
            chk("R6 transfer count", log_n - base, T_NWG[v]);
            for (int j = 0; j < T_NWG[v]; j++) begin
                chk("R6 wg_kid", log_kid[base + j], T_KID[v]);
                chk("R6 wg_idx", log_idx[base + j], j);
            end
            chk("R8 last index", log_idx[log_n - 1], T_LAST[v]);
            chk("R8 no further offer", int'(wg_valid), 0);
        end
        chk("R2 launch count", int'(stat_launch), 5);
        chk("R2 stall count", int'(stat_stall), 5);
        chk("R4 no invalidate when off", inv_n, 0);

        // R4/R5: blocked kernels rotate, invalidates requested once each
        acq_en = 1'b1;
        base = log_n;
        launch(2, 3);
        settle();
        launch(5, 2);
        settle();
        chk("R4 invalidate count", inv_n, 2);
        chk("R4 first request kid", inv_log[0], 2);
        chk("R4 second request kid", inv_log[1], 5);
        chk("R5 nothing dispatched while blocked", log_n - base, 0);
        chk("R5 pass ended", int'(wg_valid), 0);
        chk("R2 stall after blocked passes", int'(stat_stall), 7);
        @(posedge clk); #1;
        inv_done_vec[5] = 1'b1;
        settle();
        chk("R3 rise books pass", int'(stat_stall), 8);
        chk("R5 later kernel passes blocked head", log_n - base, 2);
        chk("R5 kid of passing kernel", log_kid[base], 5);
        chk("R6 idx1 of passing kernel", log_idx[base + 1], 1);
        @(posedge clk); #1;
        inv_done_vec[2] = 1'b1;
        settle();
        chk("R5 released head dispatched", log_n - base, 5);
        chk("R5 released kid", log_kid[base + 4], 2);
        chk("R6 released last idx", log_idx[base + 4], 2);
        chk("R4 no repeated request", inv_n, 2);
        @(posedge clk); #1;
        acq_en = 1'b0;
        inv_done_vec = '0;

        // R7: refusal resumes at the refused index
        refuse_idx = 6'd2;
        refuse_en  = 1'b1;
        base = log_n;
        launch(6, 5);
        settle();
        chk("R7 accepted before refusal", log_n - base, 2);
        chk("R7 pass ended on refusal", int'(wg_valid), 0);
        refuse_en = 1'b0;
        pulse_done();
        settle();
        chk("R3 wg_done books pass", int'(stat_stall), 11);
        chk("R7 total after retry", log_n - base, 5);
        chk("R7 retry resumes at refused idx", log_idx[base + 2], 2);
        chk("R7 retry kid", log_kid[base + 2], 6);
        chk("R8 retried last idx", log_idx[base + 4], 4);

        // R1/R9: fill the queue against a refusing shader
        acc = 1'b0;
        base = log_n;
        for (int k = 0; k < QDEPTH; k++) begin
            launch(k, 1);
            settle();
        end
        chk("R1 ready low when full", int'(launch_ready), 0);
        chk("R7 nothing taken while refused", log_n - base, 0);
        chk("R2 stall after fills", int'(stat_stall), 15);
        acc = 1'b1;
        pulse_done();
        settle();
        chk("R9 all dispatched", log_n - base, QDEPTH);
        for (int k = 0; k < QDEPTH; k++) begin
            chk("R9 launch order kept", log_kid[base + k], k);
        end
        chk("R1 ready again after drain", int'(launch_ready), 1);
        chk("R2 final launch count", int'(stat_launch), 12);
        chk("R2 final stall count", int'(stat_stall), 16);

        finished = 1;
        summary();
        $finish;
    end
endmodule